// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is an I2C slave that lets a bus master read and write a bank of 8-bit control registers held elsewhere on the chip. It oversamples SCL and SDA with the system clock and detects start, repeated-start and stop conditions. It compares the 7-bit device address against a parameter and acknowledges matching traffic. It drives SDA only as an open-drain pull-down enable.

A write transfer carries a 16-bit register pointer, high byte first, followed by any number of data bytes. Each data byte is presented on a one-cycle write strobe at the current pointer, and the pointer then steps by one. A read transfer has no pointer phase. The slave returns bytes from the current pointer, stepping after each byte, until the master withholds its acknowledge. A pointer-only write followed by a repeated start therefore selects where a read begins. A start or stop that arrives part-way through a byte abandons that byte.

Top module: `i2c_regbus_slave`

## Requirements
- R1: During and after reset the slave releases SDA (`sda_drive_low` = 0) and raises neither `reg_wr_en` nor `reg_rd_en` until bus traffic calls for them.
- R2: The first byte after a start holds the device address in bits 7..1 and the direction in bit 0 (0 = master writes, 1 = master reads). The slave pulls SDA low in the ninth clock only when bits 7..1 equal `DEV_ADDR`. On a mismatch it leaves SDA released for every later clock until the next start.
- R3: In a write transfer the second byte loads pointer bits 15..8 and the third byte loads bits 7..0. Each later byte is written to the pointer, which then increases by one and wraps from 0xFFFF to 0x0000. `reg_addr` always shows the pointer.
- R4: In a write transfer every byte after a matching address byte, whether pointer or data, is acknowledged by SDA low during its ninth clock.
- R5: In a read transfer the slave sends bytes MSB first from the current pointer and steps the pointer by one per byte. It changes its SDA drive only while SCL is low.
- R6: When the master leaves SDA high in the ninth clock of a read byte, the slave ends the transfer and keeps SDA released until the next start.
- R7: A start or stop that arrives before the eighth data bit of a byte drops that byte. No register write takes place and the pointer keeps its value.
- R8: A repeated start may stand in for a stop. A pointer-only write followed by a repeated-start read returns data from the loaded pointer.
- R9: There is no limit on the number of data bytes in one transfer; the pointer keeps stepping across the wrap.
- R10: `reg_wr_en` and `reg_rd_en` are single-cycle pulses that never coincide, and `reg_wr_data` and `reg_addr` are valid with `reg_wr_en`. `reg_rd_data` is taken one cycle after `reg_rd_en`. There is one read fetch for each byte the slave sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_addr | output | 16 | Register pointer, address for reads and writes |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 8 | Data for the write strobe |
| reg_rd_en | output | 1 | One-cycle register read request |
| reg_rd_data | input | 8 | Register data, valid the cycle after `reg_rd_en` |

## Verification
The assertions take it as given that the master changes SDA only while SCL is low, except when it forms a start or stop. They also assume that every SCL phase lasts several system clocks longer than the synchronizer delay, and that no start or stop is attempted while the slave is holding SDA low. The bench master holds each SCL low phase for eight cycles and moves SDA at its midpoint, and holds each high phase for eight cycles. Starts and stops are formed only from a released line. Aborted bytes are cut off only at points where the slave is not driving.

// File: rtl/i2c_rs_pkg.sv
`timescale 1ns/1ps
package i2c_rs_pkg;
  localparam int BYTE_W = 8;
  localparam int DEVA_W = 7;
  localparam int PTR_W  = 2 * BYTE_W;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_PTRH,
    ST_PTRL,
    ST_WDATA,
    ST_RDATA
  } xfer_st_t;

  // device address sits in the upper seven bits of the first byte
  function automatic logic dev_hit(input logic [BYTE_W-1:0] b,
                                   input logic [DEVA_W-1:0] dev);
    return b[BYTE_W-1:1] == dev;
  endfunction

  // pointer advance, modulo 2**PTR_W
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  // bit sent in position idx of a byte, counting from the MSB
  function automatic logic tx_bit(input logic [BYTE_W-1:0] b,
                                  input logic [2:0] idx);
    logic [2:0] pos;
    pos = 3'(BYTE_W - 1) - idx;
    return b[pos];
  endfunction
endpackage

// File: rtl/i2c_rs_sync.sv
`timescale 1ns/1ps
module i2c_rs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_rs_linecond.sv
`timescale 1ns/1ps
module i2c_rs_linecond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_rs_bitcnt.sv
`timescale 1ns/1ps
module i2c_rs_bitcnt
  import i2c_rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              active,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              ack_rise,
  output logic              slot_fall,
  output logic              end_fall
);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_POS   = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] END_POS   = CNT_W'(BYTE_W + 1);

  logic [BYTE_W-2:0] shreg;

  assign byte_done = active & scl_rise & (bit_cnt == LAST_DATA);
  assign ack_rise  = active & scl_rise & (bit_cnt == ACK_POS);
  assign slot_fall = active & scl_fall & (bit_cnt == ACK_POS);
  assign end_fall  = active & scl_fall & (bit_cnt == END_POS);
  assign rx_byte   = {shreg, sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (restart) begin
      bit_cnt <= '0;
    end else if (active) begin
      if (scl_rise && bit_cnt < END_POS) begin
        bit_cnt <= bit_cnt + CNT_W'(1);
        shreg   <= {shreg[BYTE_W-3:0], sda_s};
      end else if (end_fall) begin
        bit_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_regbus_slave.sv
`timescale 1ns/1ps
module i2c_regbus_slave
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_drive_low,
  output logic [15:0] reg_addr,
  output logic        reg_wr_en,
  output logic [7:0]  reg_wr_data,
  output logic        reg_rd_en,
  input  logic [7:0]  reg_rd_data
);
  // named internal events, also observed by the bound checker
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_byte;
  logic byte_done, ack_rise, slot_fall, end_fall;
  logic in_idle;

  xfer_st_t          state;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] tx, wr_dat;
  logic ack_pend, oe, wr_req, fetch_req, rd_pend;
  logic data_fall;

  i2c_rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
  i2c_rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  i2c_rs_linecond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  assign in_idle = (state == ST_IDLE);

  i2c_rs_bitcnt u_bits (
    .clk(clk), .rst_n(rst_n),
    .restart(start_det | stop_det), .active(!in_idle),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .bit_cnt(bit_cnt), .rx_byte(rx_byte), .byte_done(byte_done),
    .ack_rise(ack_rise), .slot_fall(slot_fall), .end_fall(end_fall));

  // falling edge that starts data bits 1..7 of a byte being sent
  assign data_fall = scl_fall && (state == ST_RDATA) &&
                     (bit_cnt >= CNT_W'(1)) && (bit_cnt <= CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      tx        <= '0;
      wr_dat    <= '0;
      ack_pend  <= 1'b0;
      oe        <= 1'b0;
      wr_req    <= 1'b0;
      fetch_req <= 1'b0;
      rd_pend   <= 1'b0;
    end else begin
      wr_req    <= 1'b0;
      fetch_req <= 1'b0;
      rd_pend   <= fetch_req;
      if (rd_pend) tx <= reg_rd_data;
      if (wr_req) ptr <= ptr_step(ptr);

      if (start_det) begin
        state    <= ST_DEVADR;
        oe       <= 1'b0;
        ack_pend <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        oe       <= 1'b0;
        ack_pend <= 1'b0;
      end else begin
        if (byte_done) begin
          case (state)
            ST_DEVADR: begin
              if (dev_hit(rx_byte, DEV_ADDR)) begin
                ack_pend <= 1'b1;
                if (rx_byte[0]) begin
                  state     <= ST_RDATA;
                  fetch_req <= 1'b1;
                end else begin
                  state <= ST_PTRH;
                end
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_PTRH: begin
              ptr[PTR_W-1:BYTE_W] <= rx_byte;
              ack_pend <= 1'b1;
              state    <= ST_PTRL;
            end
            ST_PTRL: begin
              ptr[BYTE_W-1:0] <= rx_byte;
              ack_pend <= 1'b1;
              state    <= ST_WDATA;
            end
            ST_WDATA: begin
              wr_req   <= 1'b1;
              wr_dat   <= rx_byte;
              ack_pend <= 1'b1;
            end
            default: ;
          endcase
        end

        // master's answer to a byte we sent
        if (ack_rise && state == ST_RDATA && !ack_pend) begin
          ptr <= ptr_step(ptr);
          if (sda_s) state     <= ST_IDLE;
          else       fetch_req <= 1'b1;
        end

        if (slot_fall) begin
          oe <= ack_pend;
        end else if (end_fall) begin
          ack_pend <= 1'b0;
          oe       <= (state == ST_RDATA) ? ~tx_bit(tx, 3'd0) : 1'b0;
        end else if (data_fall) begin
          oe <= ~tx_bit(tx, bit_cnt[2:0]);
        end
      end
    end
  end

  assign sda_drive_low = oe;
  assign reg_addr      = ptr;
  assign reg_wr_en     = wr_req;
  assign reg_wr_data   = wr_dat;
  assign reg_rd_en     = fetch_req;
endmodule

// File: rtl/i2c_regbus_slave_chk.sv
`timescale 1ns/1ps
module i2c_regbus_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        in_idle,
  input logic        byte_done,
  input logic        sda_drive_low,
  input logic        reg_wr_en,
  input logic        reg_rd_en,
  input logic [15:0] reg_addr
);
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en); // R10
  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en); // R10
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en)); // R10
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_s); // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_drive_low); // R6
  AST_WR_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $past(byte_done)); // R7
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr_en) |-> (reg_addr == $past(reg_addr) + 16'd1)); // R3
endmodule

bind i2c_regbus_slave i2c_regbus_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .in_idle(in_idle),
  .byte_done(byte_done), .sda_drive_low(sda_drive_low),
  .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr));

// File: tb/i2c_regbus_slave_tb.sv
`timescale 1ns/1ps
module i2c_regbus_slave_tb;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_drive_low, reg_wr_en, reg_rd_en;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wr_data, reg_rd_data;
  wire sda_bus = sda_m & ~sda_drive_low;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] exp_ptr = 16'h0000;
  logic [7:0]  exp_mem [0:255];
  logic [7:0]  rf_mem  [0:255];
  logic [15:0] wlog_a  [0:63];
  logic [7:0]  wlog_d  [0:63];
  int wlog_n;
  int rd_n;

  always #2 clk = ~clk;

  i2c_regbus_slave #(.DEV_ADDR(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_drive_low(sda_drive_low), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data));

  function automatic logic [7:0] seed_val(input int i);
    return 8'(i * 37 + 11);
  endfunction

  // register file model: one-cycle read latency, write log
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) rf_mem[i] <= seed_val(i);
      wlog_n      <= 0;
      rd_n        <= 0;
      reg_rd_data <= 8'h00;
    end else begin
      if (reg_rd_en) begin
        reg_rd_data <= rf_mem[reg_addr[7:0]];
        rd_n <= rd_n + 1;
      end
      if (reg_wr_en) begin
        rf_mem[reg_addr[7:0]] <= reg_wr_data;
        wlog_a[wlog_n[5:0]]   <= reg_addr;
        wlog_d[wlog_n[5:0]]   <= reg_wr_data;
        wlog_n <= wlog_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bus master primitives; each leaves SCL low
  task automatic m_start();
    tick(4); sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8); scl_m = 1'b0;
  endtask

  task automatic m_stop();
    tick(4); sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic m_bit_out(input logic b);
    tick(4); sda_m = b; tick(4); scl_m = 1'b1; tick(8); scl_m = 1'b0;
  endtask

  task automatic m_bit_in(output logic b);
    tick(4); sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(4);
    b = sda_bus; tick(4); scl_m = 1'b0;
  endtask

  task automatic m_byte_out(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
    m_bit_in(ack);
  endtask

  task automatic m_byte_in(output logic [7:0] v, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_bit_in(b);
      v[i] = b;
    end
    m_bit_out(nack);
  endtask

  // write transfer: pointer then n data bytes
  task automatic do_write(input logic [15:0] p, input int n, input bit rstart_end);
    logic a;
    logic [7:0] dv [0:31];
    int base;
    base = wlog_n;
    m_start();
    m_byte_out({DEV, 1'b0}, a);
    chk(a == 1'b0, "R2 address ack on match", int'(a), 0);
    m_byte_out(p[15:8], a);
    chk(a == 1'b0, "R4 pointer high ack", int'(a), 0);
    m_byte_out(p[7:0], a);
    chk(a == 1'b0, "R4 pointer low ack", int'(a), 0);
    for (int i = 0; i < n; i++) begin
      dv[i] = 8'($urandom);
      m_byte_out(dv[i], a);
      chk(a == 1'b0, "R4 data ack", int'(a), 0);
    end
    if (!rstart_end) m_stop();
    tick(4);
    chk(wlog_n - base == n, "R3 write count", wlog_n - base, n);
    for (int i = 0; i < n; i++) begin
      logic [5:0] ix;
      logic [15:0] ea;
      ix = 6'(base + i);
      ea = p + 16'(i);
      chk(wlog_a[ix] == ea, "R3 write address", int'(wlog_a[ix]), int'(ea));
      chk(wlog_d[ix] == dv[i], "R3 write data", int'(wlog_d[ix]), int'(dv[i]));
      exp_mem[ea[7:0]] = dv[i];
    end
    exp_ptr = p + 16'(n);
    chk(reg_addr == exp_ptr, "R3 pointer after write", int'(reg_addr), int'(exp_ptr));
  endtask

  // read transfer of n bytes, NACK on the last
  task automatic do_read(input int n);
    logic a;
    logic [7:0] d;
    int rbase;
    rbase = rd_n;
    m_start();
    m_byte_out({DEV, 1'b1}, a);
    chk(a == 1'b0, "R2 read address ack", int'(a), 0);
    for (int i = 0; i < n; i++) begin
      m_byte_in(d, (i == n - 1));
      chk(d == exp_mem[exp_ptr[7:0]], "R5 read data", int'(d), int'(exp_mem[exp_ptr[7:0]]));
      exp_ptr = exp_ptr + 16'd1;
    end
    tick(2);
    chk(sda_drive_low == 1'b0, "R6 released after nack", int'(sda_drive_low), 0);
    m_byte_in(d, 1'b1);
    chk(d == 8'hFF, "R6 silent after nack", int'(d), 8'hFF);
    m_stop();
    chk(rd_n - rbase == n, "R10 one fetch per byte", rd_n - rbase, n);
    chk(reg_addr == exp_ptr, "R5 pointer after read", int'(reg_addr), int'(exp_ptr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    int base;
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) exp_mem[i] = seed_val(i);

    // R1 reset state
    tick(6);
    chk(sda_drive_low == 1'b0, "R1 sda released in reset", int'(sda_drive_low), 0);
    rst_n = 1'b1;
    tick(6);
    chk(sda_drive_low == 1'b0, "R1 sda released after reset", int'(sda_drive_low), 0);
    chk(reg_wr_en == 1'b0 && reg_rd_en == 1'b0, "R1 no strobes", int'({reg_wr_en, reg_rd_en}), 0);

    // R3/R4 plain write
    do_write(16'h1234, 3, 1'b0);

    // R2 address mismatch
    base = wlog_n;
    m_start();
    m_byte_out({DEV ^ 7'h01, 1'b0}, a);
    chk(a == 1'b1, "R2 no ack on mismatch", int'(a), 1);
    m_byte_out(8'h55, a);
    chk(a == 1'b1, "R2 stays silent after mismatch", int'(a), 1);
    m_stop();
    chk(wlog_n == base, "R2 no write after mismatch", wlog_n - base, 0);
    chk(reg_addr == exp_ptr, "R2 pointer untouched", int'(reg_addr), int'(exp_ptr));

    // R3 wrap
    do_write(16'hFFFE, 3, 1'b0);
    chk(reg_addr == 16'h0001, "R3 wrap to zero", int'(reg_addr), 1);

    // R8 pointer-only write, repeated start, read
    do_write(16'h0040, 0, 1'b1);
    do_read(4);

    // R5 read continues from pointer
    do_read(3);

    // R7 stop inside a data byte
    m_start();
    m_byte_out({DEV, 1'b0}, a);
    m_byte_out(8'h00, a);
    m_byte_out(8'h80, a);
    base = wlog_n;
    m_byte_out(8'hC3, a);
    exp_mem[8'h80] = 8'hC3;
    for (int i = 0; i < 5; i++) m_bit_out(i[0]);
    m_stop();
    tick(8);
    chk(wlog_n - base == 1, "R7 partial byte not written", wlog_n - base, 1);
    chk(reg_addr == 16'h0081, "R7 pointer kept after stop", int'(reg_addr), 16'h0081);
    exp_ptr = 16'h0081;

    // R7 start inside a pointer byte
    m_start();
    m_byte_out({DEV, 1'b0}, a);
    m_bit_out(1'b1); m_bit_out(1'b0); m_bit_out(1'b1);
    m_start();
    m_byte_out({DEV, 1'b1}, a);
    chk(a == 1'b0, "R7 read address ack after abort", int'(a), 0);
    m_byte_in(d, 1'b1);
    chk(d == exp_mem[8'h81], "R7 pointer kept after start", int'(d), int'(exp_mem[8'h81]));
    exp_ptr = exp_ptr + 16'd1;
    m_stop();

    // R9 long transfer across the wrap
    do_write(16'hFFF8, 20, 1'b0);
    do_write(16'hFFF8, 0, 1'b1);
    do_read(20);
    chk(reg_addr == 16'h000C, "R9 pointer after long read", int'(reg_addr), 16'h000C);

    // mixed random traffic
    for (int k = 0; k < 24; k++) begin
      int unsigned r;
      r = $urandom;
      if (r[0]) do_write(16'($urandom), int'(r[3:1] % 5) + 1, r[4]);
      else      do_read(int'(r[3:1] % 5) + 1);
    end

    tick(10);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule